// File: doc/BRIEF.md
# Multi-Word Instruction Fetch Sequencer

This block sits between program-memory fetch and the execute stage of a small core with 16-bit instruction words. Each cycle it may receive one word, marked by a valid strobe. It sorts every leading word into an instruction class that takes one, two or three words. It then collects the extension words that follow and hands execute one assembled instruction. That instruction carries its class and all of its words in a single pulse.

Extension words can be recognised on their own: their top nibble is all ones. A word of that form that turns up where a leading word is expected is retired as a no-operation and flagged on a separate pulse. Execute can raise a skip request. The skip discards only the next leading word. Any extension words that belonged to the discarded instruction then reach the sequencer on their own, so each of them retires as a no-operation and normal flow resumes after them.

Top module: `mwf_seq`

## Requirements
- R1: A leading word is classified from its top bits, and a class code is reported with each instruction. Bits [15:12]=4'hC is a two-word register move with class code 2. Bits [15:12]=4'hE is another two-word kind with class code 3. Bits [15:5]=11'h003 is a three-word long move with class code 4. Bits [15:9]=7'b0110011 is a one-word test-and-skip with class code 1. Any other word whose bits [15:12] are not 4'hF is a one-word instruction with class code 0.
- R2: `instr_valid` pulses for exactly one cycle, in the cycle after the final word of an instruction is accepted. In that cycle `instr_words` holds word k at bits [16k+15:16k], with the leading word at k=0, and every slot the instruction does not use reads zero.
- R3: Extension words (bits [15:12]=4'hF) are collected in arrival order while an instruction is incomplete. Cycles with `word_valid` low are ignored and do not disturb a partly collected instruction.
- R4: An extension word that arrives while a leading word is expected produces a `nop_retired` pulse in the next cycle and no `instr_valid`. It leaves any pending skip pending.
- R5: A `skip_req` pulse arms a pending skip. The next leading word that is not an extension word is then discarded, whatever its length, with no output pulse, and the pending skip is cleared.
- R6: After a discarded two- or three-word leading word, each of its extension words retires as a `nop_retired` pulse. The next leading word is then decoded normally.
- R7: A leading word accepted in the same cycle as `skip_req` is decoded normally, and the skip applies to the leading word after it. If `skip_req` coincides with a discard, the skip stays armed for the following leading word.
- R8: A word that is not an extension word, arriving while an instruction is incomplete, abandons the partial instruction and is itself treated as a leading word.
- R9: Reset returns the sequencer to expecting a leading word, with no skip pending. `instr_valid` and `nop_retired` are low, and `instr_class` and `instr_words` read zero.
- R10: `instr_valid` and `nop_retired` are never high together, and neither is high in the cycle after a cycle with `word_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| word_valid | input | 1 | `word_in` carries a fetched word this cycle |
| word_in | input | 16 | Fetched instruction word |
| skip_req | input | 1 | Execute asks for the next leading word to be squashed |
| instr_valid | output | 1 | One-cycle pulse: an assembled instruction is presented |
| instr_class | output | 3 | Class code of the assembled instruction |
| instr_words | output | 48 | Up to three instruction words, leading word in the low slot |
| nop_retired | output | 1 | One-cycle pulse: a lone extension word was retired as a no-operation |

## Verification
Two functions can fall in the same cycle: arming a skip, and decoding or discarding a leading word. The bench raises `skip_req` together with a leading word, once for a one-word test-and-skip and once for a three-word move. It checks that the word in that cycle is still assembled and that the word after it is discarded. The bench also raises `skip_req` in the very cycle a pending skip discards a word, and checks that a second leading word is discarded as well before a third one comes out.

// File: rtl/mwf_pkg.sv
package mwf_pkg;
  localparam int WORD_W    = 16;
  localparam int PFX_W     = 4;
  localparam int MAX_WORDS = 3;
  localparam int CNT_W     = $clog2(MAX_WORDS + 1);
  localparam int CLS_W     = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_SINGLE = 3'd0,
    CLS_TEST   = 3'd1,
    CLS_MOVE2  = 3'd2,
    CLS_PAIR   = 3'd3,
    CLS_MOVE3  = 3'd4
  } insn_cls_e;
endpackage

// File: rtl/mwf_len_decode.sv
module mwf_len_decode
  import mwf_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic [W-1:0]  word,
  output logic          is_ext,
  output insn_cls_e     cls,
  output logic [CW-1:0] n_words
);
  localparam int TOP = W - 1;

  logic [PFX_W-1:0] nib;
  assign nib = word[TOP -: PFX_W];

  always_comb begin
    is_ext  = (nib == {PFX_W{1'b1}});
    cls     = CLS_SINGLE;
    n_words = CW'(1);
    if (nib == 4'hC) begin
      cls     = CLS_MOVE2;
      n_words = CW'(2);
    end else if (nib == 4'hE) begin
      cls     = CLS_PAIR;
      n_words = CW'(2);
    end else if (word[TOP -: 11] == 11'h003) begin
      cls     = CLS_MOVE3;
      n_words = CW'(3);
    end else if (word[TOP -: 7] == 7'b0110011) begin
      cls     = CLS_TEST;
      n_words = CW'(1);
    end
  end
endmodule

// File: rtl/mwf_skip_ctl.sv
module mwf_skip_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic skip_req,
  input  logic drop,
  output logic pending
);
  logic pend_d;

  always_comb begin
    pend_d = skip_req | (pending & ~drop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= 1'b0;
    else        pending <= pend_d;
  end

  AST_SKIP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (drop && !skip_req) |=> !pending); // R5
  AST_SKIP_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    skip_req |=> pending); // R7
endmodule

// File: rtl/mwf_seq.sv
module mwf_seq
  import mwf_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int NW = MAX_WORDS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_valid,
  input  logic [W-1:0]      word_in,
  input  logic              skip_req,
  output logic              instr_valid,
  output logic [CLS_W-1:0]  instr_class,
  output logic [NW*W-1:0]   instr_words,
  output logic              nop_retired
);
  localparam int CW = $clog2(NW + 1);

  logic            dec_ext;
  insn_cls_e       dec_cls;
  logic [CW-1:0]   dec_n;
  logic            skip_pend;

  mwf_len_decode #(.W(W), .CW(CW)) u_dec (
    .word    (word_in),
    .is_ext  (dec_ext),
    .cls     (dec_cls),
    .n_words (dec_n)
  );

  logic gath_q, gath_d;
  logic [CW-1:0] rem_q, rem_d;
  logic [CW-1:0] slot_q, slot_d;
  logic [NW-1:0][W-1:0] part_q, part_d;
  insn_cls_e pcls_q, pcls_d;

  logic lead, take, discard, ext_in, stray;
  logic emit;

  assign lead    = word_valid & ~dec_ext;
  assign discard = lead & skip_pend;
  assign take    = lead & ~skip_pend;
  assign ext_in  = word_valid & dec_ext & gath_q;
  assign stray   = word_valid & dec_ext & ~gath_q;

  mwf_skip_ctl u_skip (
    .clk      (clk),
    .rst_n    (rst_n),
    .skip_req (skip_req),
    .drop     (discard),
    .pending  (skip_pend)
  );

  always_comb begin
    gath_d = gath_q;
    rem_d  = rem_q;
    slot_d = slot_q;
    part_d = part_q;
    pcls_d = pcls_q;
    emit   = 1'b0;
    if (take) begin
      part_d    = '0;
      part_d[0] = word_in;
      pcls_d    = dec_cls;
      if (dec_n == CW'(1)) begin
        emit   = 1'b1;
        gath_d = 1'b0;
      end else begin
        gath_d = 1'b1;
        rem_d  = dec_n - CW'(1);
        slot_d = CW'(1);
      end
    end else if (ext_in) begin
      for (int k = 0; k < NW; k++) begin
        if (k == int'(slot_q)) part_d[k] = word_in;
      end
      if (rem_q == CW'(1)) begin
        emit   = 1'b1;
        gath_d = 1'b0;
      end else begin
        rem_d  = rem_q - CW'(1);
        slot_d = slot_q + CW'(1);
      end
    end else if (discard) begin
      gath_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gath_q <= 1'b0;
      rem_q  <= '0;
      slot_q <= '0;
      part_q <= '0;
      pcls_q <= CLS_SINGLE;
    end else begin
      gath_q <= gath_d;
      rem_q  <= rem_d;
      slot_q <= slot_d;
      part_q <= part_d;
      pcls_q <= pcls_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instr_valid <= 1'b0;
      nop_retired <= 1'b0;
      instr_class <= '0;
      instr_words <= '0;
    end else begin
      instr_valid <= emit;
      nop_retired <= stray;
      if (emit) begin
        instr_class <= pcls_d;
        instr_words <= part_d;
      end
    end
  end

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(instr_valid && nop_retired)); // R10
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(word_valid) |-> (!instr_valid && !nop_retired)); // R10
  AST_NOP_PREFIX: assert property (@(posedge clk) disable iff (!rst_n)
    nop_retired |-> ($past(word_valid) && ($past(word_in[W-1 -: PFX_W]) == {PFX_W{1'b1}}))); // R4
  AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(discard) |-> (!instr_valid && !nop_retired)); // R5
endmodule

// File: tb/tb_mwf_seq.sv
module tb_mwf_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 38;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        word_valid;
  logic [15:0] word_in;
  logic        skip_req;
  logic        instr_valid;
  logic [2:0]  instr_class;
  logic [47:0] instr_words;
  logic        nop_retired;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mwf_seq dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_valid  (word_valid),
    .word_in     (word_in),
    .skip_req    (skip_req),
    .instr_valid (instr_valid),
    .instr_class (instr_class),
    .instr_words (instr_words),
    .nop_retired (nop_retired)
  );

  // {skip, valid, word, exp_iv, exp_nop, exp_cls, req}
  localparam logic [26:0] VEC [NV] = '{
    {1'b0,1'b1,16'hC153,1'b0,1'b0,3'd0,4'd3},  // R3 two-word move, first word
    {1'b0,1'b1,16'hF456,1'b1,1'b0,3'd2,4'd1},  // R1 class 2
    {1'b0,1'b1,16'h2400,1'b1,1'b0,3'd0,4'd1},  // R1 class 0
    {1'b1,1'b1,16'h6600,1'b1,1'b0,3'd1,4'd7},  // R7 test word with skip
    {1'b0,1'b1,16'hC153,1'b0,1'b0,3'd0,4'd5},  // R5 discarded
    {1'b0,1'b1,16'hF456,1'b0,1'b1,3'd0,4'd6},  // R6 nop
    {1'b0,1'b1,16'h2400,1'b1,1'b0,3'd0,4'd6},  // R6 resumes
    {1'b1,1'b1,16'h6600,1'b1,1'b0,3'd1,4'd7},  // R7
    {1'b0,1'b1,16'h0060,1'b0,1'b0,3'd0,4'd5},  // R5 three-word discarded
    {1'b0,1'b1,16'hF48C,1'b0,1'b1,3'd0,4'd6},  // R6
    {1'b0,1'b1,16'hF456,1'b0,1'b1,3'd0,4'd6},  // R6
    {1'b0,1'b1,16'h2400,1'b1,1'b0,3'd0,4'd6},  // R6
    {1'b0,1'b1,16'h0060,1'b0,1'b0,3'd0,4'd3},  // R3
    {1'b0,1'b1,16'hF48C,1'b0,1'b0,3'd0,4'd3},  // R3
    {1'b0,1'b1,16'hF456,1'b1,1'b0,3'd4,4'd1},  // R1 class 4
    {1'b0,1'b1,16'hF123,1'b0,1'b1,3'd0,4'd4},  // R4 stray
    {1'b1,1'b0,16'h0000,1'b0,1'b0,3'd0,4'd10}, // R10 idle with skip
    {1'b0,1'b1,16'hF777,1'b0,1'b1,3'd0,4'd4},  // R4 skip stays armed
    {1'b0,1'b1,16'hE123,1'b0,1'b0,3'd0,4'd5},  // R5 discarded
    {1'b0,1'b1,16'hF001,1'b0,1'b1,3'd0,4'd6},  // R6
    {1'b0,1'b1,16'h2400,1'b1,1'b0,3'd0,4'd5},  // R5 skip cleared
    {1'b0,1'b1,16'hC010,1'b0,1'b0,3'd0,4'd8},  // R8
    {1'b0,1'b1,16'h2400,1'b1,1'b0,3'd0,4'd8},  // R8 abandons partial
    {1'b0,1'b1,16'hF111,1'b0,1'b1,3'd0,4'd8},  // R8 back to leading
    {1'b0,1'b1,16'hC010,1'b0,1'b0,3'd0,4'd3},  // R3
    {1'b0,1'b0,16'hF999,1'b0,1'b0,3'd0,4'd3},  // R3 invalid ignored
    {1'b0,1'b1,16'hF020,1'b1,1'b0,3'd2,4'd3},  // R3
    {1'b0,1'b1,16'hE1AB,1'b0,1'b0,3'd0,4'd1},  // R1
    {1'b0,1'b1,16'hF0CD,1'b1,1'b0,3'd3,4'd1},  // R1 class 3
    {1'b1,1'b1,16'h0070,1'b0,1'b0,3'd0,4'd7},  // R7 three-word with skip
    {1'b0,1'b1,16'hF001,1'b0,1'b0,3'd0,4'd7},  // R7
    {1'b0,1'b1,16'hF002,1'b1,1'b0,3'd4,4'd7},  // R7
    {1'b0,1'b1,16'h2400,1'b0,1'b0,3'd0,4'd5},  // R5 one-word discarded
    {1'b0,1'b1,16'h6700,1'b1,1'b0,3'd1,4'd1},  // R1 class 1
    {1'b1,1'b0,16'h0000,1'b0,1'b0,3'd0,4'd7},  // R7 arm
    {1'b1,1'b1,16'h2400,1'b0,1'b0,3'd0,4'd7},  // R7 discard + re-arm
    {1'b0,1'b1,16'h2400,1'b0,1'b0,3'd0,4'd7},  // R7 discarded again
    {1'b0,1'b1,16'h2400,1'b1,1'b0,3'd0,4'd7}   // R7
  };

  task automatic check(input string what, input int req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic sk, input logic v, input logic [15:0] w);
    @(negedge clk);
    skip_req   = sk;
    word_valid = v;
    word_in    = w;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    skip_req = 1'b0; word_valid = 1'b0; word_in = '0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic chk_words(input int req, input logic [15:0] a, input logic [15:0] b, input logic [15:0] c);
    check("word0", req, instr_words[15:0],  a);
    check("word1", req, instr_words[31:16], b);
    check("word2", req, instr_words[47:32], c);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; skip_req = 1'b0; word_valid = 1'b0; word_in = '0;
    repeat (2) @(negedge clk);
    #1;
    // R9 reset state
    check("instr_valid", 9, {15'd0, instr_valid}, 16'd0);
    check("nop_retired", 9, {15'd0, nop_retired}, 16'd0);
    check("instr_class", 9, {13'd0, instr_class}, 16'd0);
    chk_words(9, 16'h0, 16'h0, 16'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [26:0] v;
      v = VEC[i];
      step(v[26], v[25], v[24:9]);
      check("instr_valid", int'(v[3:0]), {15'd0, instr_valid}, {15'd0, v[8]});
      check("nop_retired", int'(v[3:0]), {15'd0, nop_retired}, {15'd0, v[7]});
      if (v[8]) check("instr_class", int'(v[3:0]), {13'd0, instr_class}, {13'd0, v[6:4]});
    end
    step(1'b0, 1'b0, 16'h0);

    // R2 word slots, two-word move
    step(1'b0, 1'b1, 16'hC153);
    step(1'b0, 1'b1, 16'hF456);
    chk_words(2, 16'hC153, 16'hF456, 16'h0000);
    step(1'b0, 1'b0, 16'h0);
    check("pulse length", 2, {15'd0, instr_valid}, 16'd0);
    // R2 three words in order
    step(1'b0, 1'b1, 16'h0060);
    step(1'b0, 1'b1, 16'hF48C);
    step(1'b0, 1'b1, 16'hF456);
    chk_words(2, 16'h0060, 16'hF48C, 16'hF456);
    // R2 one-word clears upper slots
    step(1'b0, 1'b1, 16'h2400);
    chk_words(2, 16'h2400, 16'h0000, 16'h0000);
    // R8 abandoned partial leaves no stale word
    step(1'b0, 1'b1, 16'hE555);
    step(1'b0, 1'b1, 16'h3333);
    chk_words(8, 16'h3333, 16'h0000, 16'h0000);

    // R9 reset mid-gather: extension word then retires as nop
    step(1'b0, 1'b1, 16'hC010);
    do_reset();
    step(1'b0, 1'b1, 16'hF020);
    check("nop after reset", 9, {15'd0, nop_retired}, 16'd1);
    check("iv after reset", 9, {15'd0, instr_valid}, 16'd0);
    // R9 reset clears pending skip
    step(1'b1, 1'b0, 16'h0);
    do_reset();
    step(1'b0, 1'b1, 16'hC153);
    step(1'b0, 1'b1, 16'hF456);
    check("iv skip cleared", 9, {15'd0, instr_valid}, 16'd1);
    chk_words(9, 16'hC153, 16'hF456, 16'h0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule